// File: doc/BRIEF.md
# RAM Self-Test Controller

This block runs a destructive self-test over a byte-wide, single-port synchronous RAM and reports the result through one 8-bit control/status register. A host sets a test code and the start bit in one register write. The controller then owns the RAM address, write-data and write-enable lines until the test ends. It checks every word it reads back and latches either a pass flag or a fail flag. The host can set a force-failure bit to confirm that the fail path works even on a healthy array.

The test menu holds fills with 0x00 or 0xFF, read-only checks of 0x00 or 0xFF, and an address-keyed ascending/descending test. It also holds a full pattern test. The full test does a zero fill, then a per-address walk through eight patterns on a zero background. It then does a ones fill and the same walk on a ones background, and ends with the ascending/descending test. The RAM depth is set by `ADDR_W`, which defaults to 15 (32K words).

The sequencer has these states. S_IDLE waits for a start. S_PHASE loads the first address of the next phase or ends the test. S_WR does a plain write and steps the address. S_RD issues a read and S_CMP compares it. S_WALK_WR, S_WALK_RD and S_WALK_CMP write, read and compare one walk pattern. S_WALK_BG restores the background and steps the address. S_DONE reports the result.

The transitions are as follows:
- S_IDLE goes to S_PHASE on a start, or to S_DONE when the code is idle.
- S_PHASE goes to S_WR for fill and ascending/descending write phases, to S_RD for verify phases, to S_WALK_RD for walk phases, and to S_DONE after the last phase.
- S_WR loops on itself until the last address, then goes to S_PHASE.
- S_RD always goes to S_CMP.
- S_CMP goes to S_DONE on a mismatch. Otherwise it returns to S_RD, or goes to S_PHASE after the last address.
- S_WALK_WR goes to S_WALK_RD, and S_WALK_RD goes to S_WALK_CMP.
- S_WALK_CMP goes to S_DONE on a mismatch, to S_WALK_BG after the eighth pattern, and to S_WALK_WR otherwise.
- S_WALK_BG goes to S_WALK_RD, or to S_PHASE after the last address.
- S_DONE goes to S_IDLE.

Top module: `ram_bist_ctrl`

## Requirements
- R1: After reset the register reads 0x00. The layout is: bit 7 force-fail, bits 6:4 test code, bit 3 start, bit 2 always 0, bit 1 fail, bit 0 pass. Bits 2:0 ignore writes.
- R2: A register write is taken only when `mode` equals 4 and no test is running. Any other write changes nothing.
- R3: Starting a test clears both flags. Bit 3 then reads 1 until the test ends and clears by itself. A test with a non-idle code ends with exactly one of pass or fail set.
- R4: Codes 000 and 111 are idle. Starting one clears start by the second clock edge after the accepted write, sets no flag and writes no RAM location.
- R5: Code 010 writes 0x00 and code 100 writes 0xFF to every address, from address 0 upward.
- R6: Code 011 reads every address and checks for 0x00, and code 101 checks for 0xFF. Both leave RAM unchanged and pass only if every word matches.
- R7: Code 001 writes the following sequence to each address: 0x00 (zero fill); then 55, AA, 33, CC, 0F, F0, 00, FF, 00 (zero-background walk); then FF (ones fill); then 55, AA, 33, CC, 0F, F0, 00, FF, FF (ones-background walk); then the ascending/descending writes of R8. Each walk step reads back and checks the word just written. Each walk starts by checking the background.
- R8: Code 110 first writes each address, ascending, with its address low byte and verifies ascending. It then writes each address, descending, with the inverted low byte and verifies descending.
- R9: The first mismatching read ends the test at once with fail set. No further RAM writes take place.
- R10: With bit 7 set, a test with a non-idle code ends with fail, not pass, even if every read matches.
- R11: Read data is compared in the cycle after the read address is presented, which matches a RAM with one cycle of read latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Device mode; register writes are accepted only at 4 |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_rdata | input | 8 | RAM read data, valid one cycle after the address |

## Verification
The bench records every RAM write. It checks the exact write history at one address through the full pattern test, so a walk pattern that is swapped, skipped or never restored shows up directly. It checks the address and data order of the ascending/descending test, so a wrong direction or a non-inverted byte fails. A stuck bit injected in the RAM model must stop the pattern test with an exact write count; a design that kept going past the first mismatch would write more. Writes in the wrong mode or during a run must leave the register and RAM untouched. A comparator that sampled read data one cycle early would fail the ascending/descending verify.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int DATA_W  = 8;
    localparam int NUM_PAT = 8;

    typedef enum logic [2:0] {
        SEL_IDLE_LO = 3'b000,
        SEL_PATTERN = 3'b001,
        SEL_FILL0   = 3'b010,
        SEL_CHK0    = 3'b011,
        SEL_FILL1   = 3'b100,
        SEL_CHK1    = 3'b101,
        SEL_INCDEC  = 3'b110,
        SEL_IDLE_HI = 3'b111
    } sel_e;

    typedef enum logic [3:0] {
        PH_FILL0, PH_WALK0, PH_FILL1, PH_WALK1,
        PH_CHK0,  PH_CHK1,  PH_INCW,  PH_INCV,
        PH_DECW,  PH_DECV,  PH_END
    } phase_e;

    // walk pattern k = 1..NUM_PAT; index 0 is the background check
    function automatic logic [DATA_W-1:0] walk_pat(input logic [3:0] k);
        unique case (k)
            4'd1:    walk_pat = 8'h55;
            4'd2:    walk_pat = 8'hAA;
            4'd3:    walk_pat = 8'h33;
            4'd4:    walk_pat = 8'hCC;
            4'd5:    walk_pat = 8'h0F;
            4'd6:    walk_pat = 8'hF0;
            4'd7:    walk_pat = 8'h00;
            4'd8:    walk_pat = 8'hFF;
            default: walk_pat = 8'h00;
        endcase
    endfunction

    function automatic logic sel_is_idle(input sel_e s);
        sel_is_idle = (s == SEL_IDLE_LO) || (s == SEL_IDLE_HI);
    endfunction

    function automatic phase_e first_phase(input sel_e s);
        unique case (s)
            SEL_PATTERN, SEL_FILL0: first_phase = PH_FILL0;
            SEL_CHK0:               first_phase = PH_CHK0;
            SEL_FILL1:              first_phase = PH_FILL1;
            SEL_CHK1:               first_phase = PH_CHK1;
            SEL_INCDEC:             first_phase = PH_INCW;
            default:                first_phase = PH_END;
        endcase
    endfunction

    function automatic phase_e next_phase(input sel_e s, input phase_e p);
        if (s == SEL_FILL0 || s == SEL_FILL1 || s == SEL_CHK0 || s == SEL_CHK1) begin
            next_phase = PH_END;
        end else begin
            unique case (p)
                PH_FILL0: next_phase = PH_WALK0;
                PH_WALK0: next_phase = PH_FILL1;
                PH_FILL1: next_phase = PH_WALK1;
                PH_WALK1: next_phase = PH_INCW;
                PH_INCW:  next_phase = PH_INCV;
                PH_INCV:  next_phase = PH_DECW;
                PH_DECW:  next_phase = PH_DECV;
                default:  next_phase = PH_END;
            endcase
        end
    endfunction

endpackage

// File: rtl/bist_cmp.sv
module bist_cmp
    import bist_pkg::*;
(
    input  logic              en,
    input  logic [DATA_W-1:0] expected,
    input  logic [DATA_W-1:0] rdata,
    output logic              mismatch
);

    always_comb begin
        mismatch = en && (rdata != expected);
    end

endmodule

// File: rtl/bist_regs.sv
module bist_regs
    import bist_pkg::*;
#(
    parameter logic [2:0] WR_MODE = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    input  logic              done_ran,
    input  logic              done_mism,
    output logic [DATA_W-1:0] rdata,
    output logic              go,
    output sel_e              sel,
    output logic              busy
);

    logic force_q, start_q, pass_q, fail_q, go_q;
    sel_e sel_q;
    logic wr_ok;
    logic fail_now;

    always_comb begin
        wr_ok    = wr && (mode == WR_MODE) && !start_q;
        fail_now = done_mism || force_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_q <= 1'b0;
            sel_q   <= SEL_IDLE_LO;
            start_q <= 1'b0;
            pass_q  <= 1'b0;
            fail_q  <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            go_q <= 1'b0;
            if (wr_ok) begin
                force_q <= wdata[7];
                sel_q   <= sel_e'(wdata[6:4]);
                if (wdata[3]) begin
                    start_q <= 1'b1;
                    pass_q  <= 1'b0;
                    fail_q  <= 1'b0;
                    go_q    <= 1'b1;
                end
            end else if (done) begin
                start_q <= 1'b0;
                if (done_ran) begin
                    fail_q <= fail_now;
                    pass_q <= !fail_now;
                end
            end
        end
    end

    always_comb begin
        rdata = {force_q, sel_q, start_q, 1'b0, fail_q, pass_q};
        go    = go_q;
        sel   = sel_q;
        busy  = start_q;
    end

    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_q && fail_q));

    a_r2_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && mode != WR_MODE) |=> $stable({force_q, sel_q}));

    a_r10_force_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ran && force_q) |=> (fail_q && !pass_q));

endmodule

// File: rtl/bist_seq.sv
module bist_seq
    import bist_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  sel_e              sel,
    input  logic              mismatch,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic              chk_en,
    output logic [DATA_W-1:0] chk_exp,
    output logic              done,
    output logic              done_ran,
    output logic              done_mism
);

    localparam int BW = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

    typedef enum logic [3:0] {
        S_IDLE, S_PHASE, S_WR, S_RD, S_CMP,
        S_WALK_WR, S_WALK_RD, S_WALK_CMP, S_WALK_BG, S_DONE
    } state_e;

    state_e            state_q, state_d;
    phase_e            phase_q, phase_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [3:0]        k_q, k_d;
    logic              mism_q, mism_d;
    logic              ran_q, ran_d;

    logic              desc;
    logic              last;
    logic [ADDR_W-1:0] addr_step;
    logic [DATA_W-1:0] addr_byte;
    logic [DATA_W-1:0] ph_data;
    logic [DATA_W-1:0] bg;

    always_comb begin
        addr_byte         = '0;
        addr_byte[BW-1:0] = addr_q[BW-1:0];
        desc      = (phase_q == PH_DECW) || (phase_q == PH_DECV);
        last      = desc ? (addr_q == '0) : (&addr_q);
        addr_step = desc ? (addr_q - 1'b1) : (addr_q + 1'b1);
        bg        = (phase_q == PH_WALK1) ? 8'hFF : 8'h00;
        unique case (phase_q)
            PH_FILL1, PH_CHK1, PH_WALK1: ph_data = 8'hFF;
            PH_INCW, PH_INCV:            ph_data = addr_byte;
            PH_DECW, PH_DECV:            ph_data = ~addr_byte;
            default:                     ph_data = 8'h00;
        endcase
    end

    // next-state and datapath update
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        addr_d  = addr_q;
        k_d     = k_q;
        mism_d  = mism_q;
        ran_d   = ran_q;
        unique case (state_q)
            S_IDLE: begin
                if (go) begin
                    mism_d = 1'b0;
                    if (sel_is_idle(sel)) begin
                        ran_d   = 1'b0;
                        state_d = S_DONE;
                    end else begin
                        ran_d   = 1'b1;
                        phase_d = first_phase(sel);
                        state_d = S_PHASE;
                    end
                end
            end
            S_PHASE: begin
                k_d    = '0;
                addr_d = ((phase_q == PH_DECW) || (phase_q == PH_DECV)) ? '1 : '0;
                unique case (phase_q)
                    PH_FILL0, PH_FILL1, PH_INCW, PH_DECW: state_d = S_WR;
                    PH_CHK0, PH_CHK1, PH_INCV, PH_DECV:   state_d = S_RD;
                    PH_WALK0, PH_WALK1:                   state_d = S_WALK_RD;
                    default:                              state_d = S_DONE;
                endcase
            end
            S_WR: begin
                if (last) begin
                    phase_d = next_phase(sel, phase_q);
                    state_d = S_PHASE;
                end else begin
                    addr_d = addr_step;
                end
            end
            S_RD: state_d = S_CMP;
            S_CMP: begin
                if (mismatch) begin
                    mism_d  = 1'b1;
                    state_d = S_DONE;
                end else if (last) begin
                    phase_d = next_phase(sel, phase_q);
                    state_d = S_PHASE;
                end else begin
                    addr_d  = addr_step;
                    state_d = S_RD;
                end
            end
            S_WALK_WR: state_d = S_WALK_RD;
            S_WALK_RD: state_d = S_WALK_CMP;
            S_WALK_CMP: begin
                if (mismatch) begin
                    mism_d  = 1'b1;
                    state_d = S_DONE;
                end else if (k_q == 4'(NUM_PAT)) begin
                    state_d = S_WALK_BG;
                end else begin
                    k_d     = k_q + 1'b1;
                    state_d = S_WALK_WR;
                end
            end
            S_WALK_BG: begin
                k_d = '0;
                if (last) begin
                    phase_d = next_phase(sel, phase_q);
                    state_d = S_PHASE;
                end else begin
                    addr_d  = addr_step;
                    state_d = S_WALK_RD;
                end
            end
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= PH_END;
            addr_q  <= '0;
            k_q     <= '0;
            mism_q  <= 1'b0;
            ran_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            addr_q  <= addr_d;
            k_q     <= k_d;
            mism_q  <= mism_d;
            ran_q   <= ran_d;
        end
    end

    // outputs
    always_comb begin
        ram_addr  = addr_q;
        ram_wdata = '0;
        ram_we    = 1'b0;
        chk_en    = 1'b0;
        chk_exp   = '0;
        done      = 1'b0;
        done_ran  = ran_q;
        done_mism = mism_q;
        unique case (state_q)
            S_WR: begin
                ram_we    = 1'b1;
                ram_wdata = ph_data;
            end
            S_CMP: begin
                chk_en  = 1'b1;
                chk_exp = ph_data;
            end
            S_WALK_WR: begin
                ram_we    = 1'b1;
                ram_wdata = walk_pat(k_q);
            end
            S_WALK_CMP: begin
                chk_en  = 1'b1;
                chk_exp = (k_q == '0) ? bg : walk_pat(k_q);
            end
            S_WALK_BG: begin
                ram_we    = 1'b1;
                ram_wdata = bg;
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    a_r9_stop_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_CMP || state_q == S_WALK_CMP) && mismatch) |=> (state_q == S_DONE));

    a_r11_read_then_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP) |-> ($past(state_q) == S_RD));

    a_r11_walk_read_then_compare: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WALK_CMP) |-> ($past(state_q) == S_WALK_RD));

endmodule

// File: rtl/ram_bist_ctrl.sv
module ram_bist_ctrl
    import bist_pkg::*;
#(
    parameter int         ADDR_W  = 15,
    parameter logic [2:0] WR_MODE = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              ram_we,
    input  logic [7:0]        ram_rdata
);

    logic              go, busy, done, done_ran, done_mism;
    sel_e              sel;
    logic              chk_en, mismatch;
    logic [DATA_W-1:0] chk_exp;

    bist_regs #(.WR_MODE(WR_MODE)) u_regs (
        .clk(clk), .rst_n(rst_n), .mode(mode), .wr(reg_wr), .wdata(reg_wdata),
        .done(done), .done_ran(done_ran), .done_mism(done_mism),
        .rdata(reg_rdata), .go(go), .sel(sel), .busy(busy)
    );

    bist_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .sel(sel), .mismatch(mismatch),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .chk_en(chk_en), .chk_exp(chk_exp),
        .done(done), .done_ran(done_ran), .done_mism(done_mism)
    );

    bist_cmp u_cmp (
        .en(chk_en), .expected(chk_exp), .rdata(ram_rdata), .mismatch(mismatch)
    );

    a_r3_write_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> busy);

    a_r4_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (go && sel_is_idle(sel)) |=> !ram_we);

endmodule

// File: tb/ram_bist_ctrl_test.sv
module ram_bist_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;
    localparam int LOG_MAX    = 2048;
    localparam int LOG_ADDR   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = 3'd0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_wdata;
    logic          ram_we;
    logic [7:0]    ram_rdata;

    int errors = 0;
    int checks = 0;

    // RAM model with optional stuck-at-1 fault, preload and write log
    logic [7:0]    mem [DEPTH];
    logic [7:0]    rdq;
    logic          fault_en = 1'b0;
    int            fault_addr = 0;
    logic [7:0]    fault_mask = 8'h00;
    logic          pre_go = 1'b0;
    int            pre_kind = 0;
    logic [7:0]    pre_seed = 8'h00;
    logic          log_clr = 1'b0;
    int            log_n = 0;
    int            log_a [LOG_MAX];
    logic [7:0]    log_d [LOG_MAX];

    assign ram_rdata = rdq;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (pre_go) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= (pre_kind == 0) ? 8'h00 : (pre_kind == 1) ? 8'hFF : 8'(i * 37 + pre_seed);
            end
        end else if (ram_we) begin
            mem[ram_addr] <= ram_wdata;
        end
        rdq <= mem[ram_addr] | ((fault_en && int'(ram_addr) == fault_addr) ? fault_mask : 8'h00);
        if (log_clr) begin
            log_n = 0;
        end else if (ram_we && log_n < LOG_MAX) begin
            log_a[log_n] = int'(ram_addr);
            log_d[log_n] = ram_wdata;
            log_n = log_n + 1;
        end
    end

    ram_bist_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, actual, expected);
        end
    endtask

    task automatic reg_write(input logic [2:0] m, input logic [7:0] d);
        @(negedge clk);
        mode = m; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; mode = 3'd0;
    endtask

    task automatic preload(input int kind, input logic [7:0] seed);
        @(negedge clk);
        pre_kind = kind; pre_seed = seed; pre_go = 1'b1;
        @(negedge clk);
        pre_go = 1'b0;
    endtask

    task automatic clear_log();
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            if (!reg_rdata[3]) return;
            @(negedge clk);
        end
    endtask

    task automatic run(input logic [2:0] s, input logic f);
        clear_log();
        reg_write(3'd4, {f, s, 1'b1, 3'b000});
        wait_done();
    endtask

    // expected flags {fail, pass} from the requirements
    function automatic logic [1:0] exp_flags(input logic [2:0] s, input logic f);
        logic bad;
        bad = 1'b0;
        if (s == 3'b000 || s == 3'b111) return 2'b00;
        if (s == 3'b011 || s == 3'b101) begin
            for (int i = 0; i < DEPTH; i++) begin
                if ((mem[i] | ((fault_en && i == fault_addr) ? fault_mask : 8'h00))
                        != ((s == 3'b011) ? 8'h00 : 8'hFF)) bad = 1'b1;
            end
        end else if (s != 3'b010 && s != 3'b100) begin
            bad = fault_en;
        end
        return (bad || f) ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [7:0] exp_pat_write(input int i);
        logic [7:0] w [9];
        w[0] = 8'h55; w[1] = 8'hAA; w[2] = 8'h33; w[3] = 8'hCC;
        w[4] = 8'h0F; w[5] = 8'hF0; w[6] = 8'h00; w[7] = 8'hFF;
        if (i == 0) return 8'h00;
        if (i <= 8) return w[i-1];
        if (i == 9) return 8'h00;
        if (i == 10) return 8'hFF;
        if (i <= 18) return w[i-11];
        if (i == 19) return 8'hFF;
        if (i == 20) return 8'(LOG_ADDR);
        return ~8'(LOG_ADDR);
    endfunction

    // fills and full tests leave a known image; returns 1 when RAM matches
    function automatic int mem_is(input int kind);
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] e;
            e = (kind == 0) ? 8'h00 : (kind == 1) ? 8'hFF : ~8'(i);
            if (mem[i] != e) return 0;
        end
        return 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] snap [DEPTH];
        int same;
        int ok;
        logic [1:0] ef;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset value
        check("R1 reset value", reg_rdata, 8'h00);
        check("R1 no write after reset", ram_we, 0);

        // R2: write in wrong mode ignored (would start a pattern test)
        clear_log();
        reg_write(3'd3, 8'h98);
        repeat (4) @(negedge clk);
        check("R2 wrong-mode write ignored", reg_rdata, 8'h00);
        check("R2 wrong-mode no RAM activity", log_n, 0);

        // R1: bits 2:0 not writable
        reg_write(3'd4, 8'h07);
        @(negedge clk);
        check("R1 low bits read-only", reg_rdata, 8'h00);

        // R4: idle code completes within two edges, no writes
        preload(2, 8'h11);
        clear_log();
        reg_write(3'd4, 8'h78);
        @(negedge clk);
        @(negedge clk);
        check("R4 idle code 111 completes", reg_rdata, 8'h70);
        check("R4 idle writes nothing", log_n, 0);

        // R5: fill zero and fill ones
        run(3'b010, 1'b0);
        check("R5 fill 0x00 flags", reg_rdata[1:0], 2'b01);
        check("R5 fill 0x00 contents", mem_is(0), 1);
        ok = 1;
        for (int i = 0; i < DEPTH; i++) if (log_a[i] != i) ok = 0;
        check("R5 fill ascending order", ok, 1);
        reg_write(3'd4, 8'h27);
        @(negedge clk);
        check("R1 read-only flags kept", reg_rdata, 8'h21);
        run(3'b100, 1'b0);
        check("R5 fill 0xFF contents", mem_is(1), 1);

        // R6: verify ones passes, verify zero fails, RAM unchanged
        run(3'b101, 1'b0);
        check("R6 verify 0xFF pass", reg_rdata[1:0], 2'b01);
        run(3'b011, 1'b0);
        check("R6 verify 0x00 on ones fails", reg_rdata[1:0], 2'b10);
        check("R6 verify leaves RAM", mem_is(1), 1);

        // R7: full pattern test write history at one address
        run(3'b001, 1'b0);
        check("R7 pattern pass", reg_rdata, 8'h11);
        ok = 1; same = 0;
        for (int i = 0; i < log_n; i++) begin
            if (log_a[i] == LOG_ADDR) begin
                if (same > 21 || log_d[i] != exp_pat_write(same)) ok = 0;
                same++;
            end
        end
        check("R7 pattern write count at address", same, 22);
        check("R7 pattern write sequence", ok, 1);
        check("R7 final image", mem_is(2), 1);

        // R8 / R11: inc/dec order and data with varying read data
        preload(2, 8'h5A);
        run(3'b110, 1'b0);
        check("R8 R11 incdec pass", reg_rdata[1:0], 2'b01);
        check("R8 incdec write count", log_n, 2 * DEPTH);
        ok = 1;
        for (int i = 0; i < DEPTH; i++) begin
            if (log_a[i] != i || log_d[i] != 8'(i)) ok = 0;
            if (log_a[DEPTH+i] != DEPTH-1-i || log_d[DEPTH+i] != ~8'(DEPTH-1-i)) ok = 0;
        end
        check("R8 incdec order and data", ok, 1);

        // R9: stuck bit at address 5 stops the walk on its background read
        fault_en = 1'b1; fault_addr = 5; fault_mask = 8'h01;
        run(3'b001, 1'b0);
        check("R9 stuck bit fails", reg_rdata[1:0], 2'b10);
        check("R9 stop after first mismatch", log_n, DEPTH + 5 * 9);
        fault_en = 1'b0;

        // R10: force fail on a clean run
        run(3'b010, 1'b1);
        check("R10 forced fail", reg_rdata, 8'hA2);
        check("R10 forced run still fills", mem_is(0), 1);

        // R2 / R3: write during a run is ignored, start reads 1 while running
        clear_log();
        reg_write(3'd4, 8'h18);
        repeat (20) @(negedge clk);
        check("R3 start held while running", reg_rdata[3], 1);
        check("R3 flags cleared at start", reg_rdata[1:0], 2'b00);
        reg_write(3'd4, 8'h00);
        wait_done();
        check("R2 busy write ignored", reg_rdata, 8'h11);

        // random mix (R3 exactly one flag)
        for (int n = 0; n < 12; n++) begin
            logic [2:0] s;
            logic f;
            s = 3'($urandom % 8);
            f = (($urandom % 4) == 0);
            preload(int'($urandom % 3), 8'($urandom));
            for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
            ef = exp_flags(s, f);
            run(s, f);
            check($sformatf("R3 random code %0d force %0d flags", s, f), reg_rdata[1:0], ef);
            check("R3 random start cleared", reg_rdata[3], 0);
            if (s == 3'b011 || s == 3'b101 || s == 3'b000 || s == 3'b111) begin
                ok = 1;
                for (int i = 0; i < DEPTH; i++) if (mem[i] != snap[i]) ok = 0;
                check("R6 random RAM untouched", ok, 1);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule